// File: doc/BRIEF.md
# Shared Interrupt Distributor

The block takes a set of shared interrupt request lines and routes each one to the interrupt inputs of several processor cores. Each shared line has its own settings: a set of destination cores, a distribution scheme, a trigger type and a block bit. There is also one global enable. Software sets all of these through a single-cycle command port. Each command carries an operation code, a line index and a data word.

A line can go to one fixed core, which is the lowest core set in its destination set. It can also rotate among all the cores in that set, so that interrupt load is spread in hardware. In rotation, a core keeps an asserted level request until the request drops. The next assertion then goes to the next core in the set. Each core sees its own bank of lines: shared line i drives line i of the core that owns it. Outputs are registered, so a change on an input shows at the outputs one clock later.

Top module: `cirq_distributor`

## Requirements
- R1: After reset all outputs are low, every line is blocked, every destination set is empty and every line is in fixed-destination level mode.
- R2: Operation code 4 sets the global enable to data bit 0. While the enable is 0, every output stays low. The enable is 0 after reset.
- R3: Operation code 1 writes data bits [N_CORE-1:0] as the destination set of the indexed line, one bit per core. A line is never delivered to a core outside its destination set.
- R4: Operation code 2 writes the mode of the indexed line. If data[1:0] is 00 the line uses rotation; any other value selects fixed destination. data[4]=1 selects level trigger and 0 selects edge trigger. All other data bits are ignored.
- R5: In fixed-destination mode the line goes only to the lowest-numbered core in its destination set.
- R6: In rotation mode, successive assertions go to the set cores in rising core order, wrapping from the highest core back to the lowest. After reset the search starts at core 0.
- R7: In rotation mode the selected core is held while the input stays high. The rotation moves on only when the input falls.
- R8: Operation code 3 with data bit 0 = 1 blocks the indexed line, and data bit 0 = 0 unblocks it. A blocked line drives no output.
- R9: Shared line i for core c appears on core_irq bit c*N_IRQ+i, one clock after the input is sampled.
- R10: With level trigger, the output follows the input one clock later. With edge trigger, a rising input gives a single one-clock pulse. A low input never drives an output.
- R11: A line whose destination set is empty is never forwarded.
- R12: Each shared line drives at most one core at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Operation: 1 destination, 2 mode, 3 block, 4 enable |
| cmd_idx | input | IDX_W | Shared line index; indices at or above N_IRQ are ignored |
| cmd_data | input | DATA_W | Command data word |
| irq_in | input | N_IRQ | Shared interrupt request inputs |
| core_irq | output | N_CORE*N_IRQ | Per-core interrupt lines, core c line i at bit c*N_IRQ+i |

## Verification
The rotation test uses a destination set with a gap and a wrap: cores 0, 1 and 3 of four. A design that steps one core at a time instead of searching would hand the third assertion to core 2. A design that skips the wrap would never return to core 0. Holding the input over several cycles catches a rotation that advances on every clock rather than on the falling edge. A wrong lowest-bit pick shows up as delivery to core 2 for a destination set of cores 1 and 2. An edge-triggered line held high exposes a missing edge detector, which would drive a level instead of a single pulse. Disable, block and empty-set cases catch any forwarding path that ignores one of those gates. A random phase compares every output on every clock against the behavioural model.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_DEST   = 3'd1,
    OP_MODE   = 3'd2,
    OP_BLOCK  = 3'd3,
    OP_ENABLE = 3'd4
  } cirq_op_e;

  localparam logic [1:0] SCHEME_ROTATE   = 2'b00;
  localparam logic [1:0] SCHEME_FIXED_RV = 2'b10;
  localparam int         MODE_LEVEL_BIT  = 4;
  localparam int         CORE_CAP        = 8;

  // First set core at or after `start`, searching cyclically over n cores.
  function automatic int unsigned pick_core(input logic [CORE_CAP-1:0] dest,
                                            input int unsigned start,
                                            input int unsigned n);
    int unsigned sel;
    sel = 0;
    for (int k = CORE_CAP - 1; k >= 0; k--) begin
      if (k < int'(n)) begin
        if (dest[(start + k) % n]) sel = (start + k) % n;
      end
    end
    return sel;
  endfunction

  function automatic int unsigned next_core(input int unsigned c, input int unsigned n);
    return (c + 1) % n;
  endfunction

endpackage

// File: rtl/cirq_cfg_regs.sv
module cirq_cfg_regs
  import cirq_pkg::*;
#(
  parameter int N_IRQ  = 6,
  parameter int N_CORE = 4,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  input  logic [2:0]                    cmd_op,
  input  logic [IDX_W-1:0]              cmd_idx,
  input  logic [DATA_W-1:0]             cmd_data,
  output logic [N_IRQ-1:0][N_CORE-1:0]  dest_o,
  output logic [N_IRQ-1:0]              rotate_o,
  output logic [N_IRQ-1:0]              level_o,
  output logic [N_IRQ-1:0]              block_o,
  output logic                          enable_o
);

  cirq_op_e op;
  assign op = cirq_op_e'(cmd_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               enable_o <= 1'b0;
    else if (cmd_valid && op == OP_ENABLE)    enable_o <= cmd_data[0];
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    logic hit;
    assign hit = cmd_valid && (int'(cmd_idx) == i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dest_o[i]   <= '0;
        rotate_o[i] <= (SCHEME_FIXED_RV == SCHEME_ROTATE);
        level_o[i]  <= 1'b1;
        block_o[i]  <= 1'b1;
      end else if (hit) begin
        case (op)
          OP_DEST:  dest_o[i] <= cmd_data[N_CORE-1:0];
          OP_MODE: begin
            rotate_o[i] <= (cmd_data[1:0] == SCHEME_ROTATE);
            level_o[i]  <= cmd_data[MODE_LEVEL_BIT];
          end
          OP_BLOCK: block_o[i] <= cmd_data[0];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cirq_lane.sv
module cirq_lane
  import cirq_pkg::*;
#(
  parameter int N_CORE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_in,
  input  logic              enable,
  input  logic              blocked,
  input  logic              rotate,
  input  logic              level,
  input  logic [N_CORE-1:0] dest,
  output logic [N_CORE-1:0] lines_q
);

  localparam int PTR_W = $clog2(N_CORE);

  logic             in_q;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] target;
  logic             req_now;
  logic             fell;
  logic             deliver;
  logic             have_dest;

  assign have_dest = |dest;
  assign req_now   = level ? req_in : (req_in & ~in_q);
  assign fell      = in_q & ~req_in;
  assign target    = PTR_W'(pick_core(CORE_CAP'(dest),
                                      rotate ? int'(ptr_q) : 0, N_CORE));
  assign deliver   = enable & ~blocked & req_now & have_dest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= 1'b0;
      ptr_q   <= '0;
      lines_q <= '0;
    end else begin
      in_q    <= req_in;
      lines_q <= deliver ? (N_CORE'(1) << target) : '0;
      if (fell && rotate && have_dest)
        ptr_q <= PTR_W'(next_core(int'(target), N_CORE));
    end
  end

  assert_dest_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lines_q & ~$past(dest)) == '0);

  assert_blocked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> lines_q == '0);

  assert_rotation_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_q && req_in) |=> $stable(ptr_q));

  assert_low_input_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_in |=> lines_q == '0);

  assert_one_core_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lines_q) <= 1);

endmodule

// File: rtl/cirq_distributor.sv
module cirq_distributor
  import cirq_pkg::*;
#(
  parameter int N_IRQ  = 6,
  parameter int N_CORE = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_op,
  input  logic [IDX_W-1:0]         cmd_idx,
  input  logic [DATA_W-1:0]        cmd_data,
  input  logic [N_IRQ-1:0]         irq_in,
  output logic [N_CORE*N_IRQ-1:0]  core_irq
);

  logic [N_IRQ-1:0][N_CORE-1:0] dest;
  logic [N_IRQ-1:0]             rotate;
  logic [N_IRQ-1:0]             level;
  logic [N_IRQ-1:0]             blocked;
  logic                         en_q;

  cirq_cfg_regs #(
    .N_IRQ(N_IRQ), .N_CORE(N_CORE), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .dest_o(dest), .rotate_o(rotate), .level_o(level), .block_o(blocked),
    .enable_o(en_q)
  );

  for (genvar i = 0; i < N_IRQ; i++) begin : g_lane
    logic [N_CORE-1:0] lines;

    cirq_lane #(.N_CORE(N_CORE)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .req_in(irq_in[i]), .enable(en_q), .blocked(blocked[i]),
      .rotate(rotate[i]), .level(level[i]), .dest(dest[i]),
      .lines_q(lines)
    );

    for (genvar c = 0; c < N_CORE; c++) begin : g_map
      assign core_irq[c*N_IRQ + i] = lines[c];
    end
  end

  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> core_irq == '0);

  assert_empty_set_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dest[0] == '0) |=> core_irq[0] == 1'b0);

endmodule

// File: tb/cirq_distributor_bench.sv
module cirq_distributor_bench;

  localparam int NI = 6;
  localparam int NC = 4;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             cmd_valid = 0;
  logic [2:0]       cmd_op = 0;
  logic [2:0]       cmd_idx = 0;
  logic [31:0]      cmd_data = 0;
  logic [NI-1:0]    irq_in = 0;
  logic [NC*NI-1:0] core_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cirq_distributor #(.N_IRQ(NI), .N_CORE(NC)) u_cirq_distributor (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .irq_in(irq_in), .core_irq(core_irq)
  );

  // behavioural reference model
  int m_dest[NI];
  int m_ptr[NI];
  bit m_rot[NI], m_lvl[NI], m_blk[NI], m_prev[NI];
  bit m_en;
  logic [NC*NI-1:0] exp_out;
  logic [NC*NI-1:0] nxt;
  int  t;
  bit  rq;

  function automatic int mpick(int d, int start);
    for (int k = 0; k < NC; k++) begin
      if (d[(start + k) % NC]) return (start + k) % NC;
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NI; i++) begin
        m_dest[i] = 0; m_ptr[i] = 0; m_rot[i] = 0; m_lvl[i] = 1;
        m_blk[i] = 1; m_prev[i] = 0;
      end
      m_en = 0;
      exp_out = '0;
    end else begin
      nxt = '0;
      for (int i = 0; i < NI; i++) begin
        rq = m_lvl[i] ? irq_in[i] : (irq_in[i] && !m_prev[i]);
        t  = mpick(m_dest[i], m_rot[i] ? m_ptr[i] : 0);
        if (m_en && !m_blk[i] && rq && m_dest[i] != 0) nxt[t*NI + i] = 1'b1;
        if (m_prev[i] && !irq_in[i] && m_rot[i] && m_dest[i] != 0) m_ptr[i] = (t + 1) % NC;
        m_prev[i] = irq_in[i];
      end
      exp_out = nxt;
      if (cmd_valid) begin
        if (cmd_op == 3'd4) m_en = cmd_data[0];
        else if (int'(cmd_idx) < NI) begin
          case (cmd_op)
            3'd1: m_dest[cmd_idx] = int'(cmd_data[NC-1:0]);
            3'd2: begin m_rot[cmd_idx] = (cmd_data[1:0] == 2'b00); m_lvl[cmd_idx] = cmd_data[4]; end
            3'd3: m_blk[cmd_idx] = cmd_data[0];
            default: ;
          endcase
        end
      end
    end
  end

  // every-cycle comparison against the model (R9, R12)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (core_irq !== exp_out) begin
        errors++;
        $display("FAIL R9 model compare at %0t: actual %h expected %h", $time, core_irq, exp_out);
      end
    end
  end

  task automatic chk_line(input int core, input int line, input bit val, input string tag);
    checks++;
    if (core_irq[core*NI + line] !== val) begin
      errors++;
      $display("FAIL %s core %0d line %0d: actual %b expected %b", tag, core, line,
               core_irq[core*NI + line], val);
    end
  endtask

  task automatic chk_zero(input string tag);
    checks++;
    if (core_irq !== '0) begin
      errors++;
      $display("FAIL %s: actual %h expected 0", tag, core_irq);
    end
  endtask

  task automatic send(input logic [2:0] op, input int idx, input logic [31:0] d);
    cmd_valid = 1; cmd_op = op; cmd_idx = 3'(idx); cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_zero("R1 reset state");

    // nothing configured: inputs high, outputs stay low (R1)
    irq_in = '1;
    repeat (3) @(negedge clk);
    chk_zero("R1 blocked after reset");
    irq_in = '0;

    // line 0: fixed mode, level, set {1,2}; not yet enabled (R2)
    send(3'd1, 0, 32'h6);
    send(3'd2, 0, 32'h12);
    send(3'd3, 0, 32'h0);
    irq_in[0] = 1;
    repeat (2) @(negedge clk);
    chk_zero("R2 not enabled");
    send(3'd4, 0, 32'h1);
    @(negedge clk);
    chk_line(1, 0, 1, "R5 lowest core R9 mapping");
    chk_line(2, 0, 0, "R5 second core unused");

    // block and unblock (R8)
    send(3'd3, 0, 32'h1);
    @(negedge clk);
    chk_zero("R8 blocked");
    send(3'd3, 0, 32'h0);
    @(negedge clk);
    chk_line(1, 0, 1, "R8 unblocked");
    irq_in[0] = 0;
    @(negedge clk);
    @(negedge clk);
    chk_line(1, 0, 0, "R10 level follows low");

    // line 2: rotation over {0,1,3} (R6, R7)
    send(3'd1, 2, 32'hB);
    send(3'd2, 2, 32'h10);
    send(3'd3, 2, 32'h0);
    begin
      int seq[4] = '{0, 1, 3, 0};
      for (int n = 0; n < 4; n++) begin
        irq_in[2] = 1;
        @(negedge clk);
        chk_line(seq[n], 2, 1, "R6 rotation order");
        @(negedge clk);
        @(negedge clk);
        chk_line(seq[n], 2, 1, "R7 core held while high");
        irq_in[2] = 0;
        @(negedge clk);
        @(negedge clk);
      end
    end

    // line 3: edge trigger, fixed to core 3 (R10)
    send(3'd1, 3, 32'h8);
    send(3'd2, 3, 32'h02);
    send(3'd3, 3, 32'h0);
    irq_in[3] = 1;
    @(negedge clk);
    chk_line(3, 3, 1, "R10 edge pulse");
    @(negedge clk);
    chk_line(3, 3, 0, "R10 edge single cycle");
    @(negedge clk);
    chk_line(3, 3, 0, "R10 edge no repeat");
    irq_in[3] = 0;
    @(negedge clk);

    // line 4: empty destination set (R11)
    send(3'd2, 4, 32'h10);
    send(3'd3, 4, 32'h0);
    irq_in[4] = 1;
    repeat (2) @(negedge clk);
    chk_zero("R11 empty set");
    irq_in[4] = 0;

    // line 5: reserved bits set, scheme 00 => rotation, bit4 = 1 level (R4, R3)
    send(3'd1, 5, 32'hFFFF_FFF4);
    send(3'd2, 5, 32'hFFFF_FFFC);
    send(3'd3, 5, 32'h0);
    irq_in[5] = 1;
    @(negedge clk);
    chk_line(2, 5, 1, "R4 reserved bits ignored R3 set");
    @(negedge clk);
    chk_line(2, 5, 1, "R4 level kept");
    irq_in[5] = 0;
    @(negedge clk);

    // global disable (R2)
    irq_in[0] = 1;
    send(3'd4, 0, 32'h0);
    @(negedge clk);
    chk_zero("R2 disabled");
    irq_in[0] = 0;
    send(3'd4, 0, 32'h1);

    // random phase with model compare every cycle (R9, R12)
    for (int i = 0; i < NI; i++) begin
      send(3'd1, i, 32'(1 + (i * 5) % 15));
      send(3'd2, i, (i % 2 == 0) ? 32'h10 : ((i % 3 == 0) ? 32'h02 : 32'h11));
      send(3'd3, i, 32'h0);
    end
    for (int n = 0; n < 600; n++) begin
      irq_in = NI'($urandom);
      if (n % 97 == 50) send(3'd1, n % NI, 32'($urandom));
      else if (n % 131 == 70) send(3'd3, n % NI, 32'($urandom % 2));
      else @(negedge clk);
    end
    irq_in = '0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule